// File: doc/BRIEF.md
# SD/MMC Host Power State Sequencer

This block owns the power state of an SD/MMC host port. A 2-bit power field and a direction-polarity bit are loaded through a single-cycle write strobe. From the stored field the block decides whether the card clock, command and data pads are released (high impedance), held low, held high, or handed over to the command and data engines. It also decides whether the card clock may toggle and whether those engines may run.

Two encodings have a special meaning. The field reads 00 after reset, the same code as power-off. Even so, the reset state and a written power-off state drive the pads differently. After reset the pads float. After a written power-off they are held high. Power-cycle holds every line low, so the card cannot draw supply current through its signal pins. Entering power-on starts the card clock at once. The engines stay disabled until a fixed number of card clock periods has elapsed. The block counts those periods from a one-cycle strobe, `ck_tick_i`, supplied by the clock generator.

Top module: `host_pwr_seq`

## Requirements
- R1: After reset, `pwr_field_o` is 00 and `dir_pol_o` is 0. The pads are released (`pad_oe_o`=0), and `ck_run_o`, `eng_en_o` and `ready_o` are all 0.
- R2: One cycle after a write of 00, the pads are driven high (`pad_oe_o`=1, `pad_lvl_o`=1), and `ck_run_o`, `eng_en_o` and `ready_o` are 0.
- R3: Code 01 is reserved. After it is written, the outputs are the same as for power-off (R2), and `pwr_field_o` reads 01.
- R4: One cycle after a write of 10 (power-cycle), the pads are driven low (`pad_oe_o`=1, `pad_lvl_o`=0), and `ck_run_o`, `eng_en_o` and `ready_o` are 0.
- R5: One cycle after a write of 11 (power-on) from another state, `ck_run_o`=1 and the pads are driven high. `eng_en_o` and `ready_o` stay 0 until the startup count completes.
- R6: In power-on, `ready_o` and `eng_en_o` become 1 on the cycle after the edge that samples the STARTUP_TICKS-th `ck_tick_i` pulse (default 74). From then on `pad_oe_o`=0, because the engines own the pads. `eng_en_o` is never 1 while `ready_o` is 0.
- R7: A write of any code other than 11 clears `ready_o` on the next cycle and resets the startup count. A later power-on then needs the full STARTUP_TICKS pulses again.
- R8: A write of 11 while already in power-on neither restarts the count nor clears `ready_o`.
- R9: `ck_tick_i` pulses that arrive outside power-on are not counted.
- R10: Every write loads `cfg_dirpol_i` into `dir_pol_o` and `cfg_pwr_i` into `pwr_field_o`, and both outputs are visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the power field and polarity bit |
| cfg_pwr_i | input | 2 | Power code: 00 off, 01 reserved (off), 10 cycle, 11 on |
| cfg_dirpol_i | input | 1 | Direction-polarity value for the level translator |
| ck_tick_i | input | 1 | One pulse per card clock period |
| pwr_field_o | output | 2 | Stored power code |
| dir_pol_o | output | 1 | Direction-signal polarity for the external translator |
| pad_oe_o | output | 1 | Sequencer drives card clock, command and data pads |
| pad_lvl_o | output | 1 | Level forced on the pads while `pad_oe_o` is 1 |
| ck_run_o | output | 1 | Card clock allowed to toggle |
| eng_en_o | output | 1 | Command and data engines enabled |
| ready_o | output | 1 | Startup count complete in power-on |

## Verification
On every cycle, the assertions check the following: each write's effect on the pad drive one cycle later; that the engines never run while the block is not ready; that `ready_o` only rises on a counted tick; that a non-on write clears the count; and that rewriting power-on keeps readiness. Only the bench scenarios can show that the reset state differs from a written power-off, that readiness arrives on exactly the 74th tick and not the 73rd, that ticks outside power-on are ignored, and that reserved code 01 reads back while behaving as off.

// File: rtl/host_pwr_pkg.sv
package host_pwr_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ   = 2'd0,
    MODE_OFF   = 2'd1,
    MODE_CYCLE = 2'd2,
    MODE_ON    = 2'd3
  } pwr_mode_e;

  localparam logic [1:0] CODE_OFF   = 2'b00;
  localparam logic [1:0] CODE_RSVD  = 2'b01;
  localparam logic [1:0] CODE_CYCLE = 2'b10;
  localparam logic [1:0] CODE_ON    = 2'b11;
endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import host_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] pwr_i,
  input  logic       dirpol_i,
  output logic [1:0] field_o,
  output logic       dirpol_o,
  output pwr_mode_e  mode_o
);
  logic [1:0] field_q;
  logic       dirpol_q;
  logic       hiz_q;   // set by reset, left on first write

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q  <= CODE_OFF;
      dirpol_q <= 1'b0;
      hiz_q    <= 1'b1;
    end else if (we_i) begin
      field_q  <= pwr_i;
      dirpol_q <= dirpol_i;
      hiz_q    <= 1'b0;
    end
  end

  always_comb begin
    if (hiz_q)                     mode_o = MODE_HIZ;
    else if (field_q == CODE_ON)   mode_o = MODE_ON;
    else if (field_q == CODE_CYCLE) mode_o = MODE_CYCLE;
    else                           mode_o = MODE_OFF;
  end

  assign field_o  = field_q;
  assign dirpol_o = dirpol_q;

  a_r10_field_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (field_o == $past(pwr_i)) && (dirpol_o == $past(dirpol_i)));
  a_r10_field_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(field_o) && $stable(dirpol_o));
endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int unsigned STARTUP_TICKS = 74,
  localparam int unsigned CW = $clog2(STARTUP_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic ready_o
);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (run_i && !ready_q && tick_i) begin
      if (cnt_q == LAST) ready_q <= 1'b1;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign ready_o = ready_q;

  a_r7_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ready_o && (cnt_q == '0));
  a_r6_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(tick_i) && $past(run_i));
  a_r9_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q) || (cnt_q == '0));
endmodule

// File: rtl/pad_decode.sv
module pad_decode
  import host_pwr_pkg::*;
(
  input  pwr_mode_e mode_i,
  input  logic      ready_i,
  output logic      pad_oe_o,
  output logic      pad_lvl_o,
  output logic      ck_run_o,
  output logic      eng_en_o
);
  always_comb begin
    pad_oe_o  = 1'b0;
    pad_lvl_o = 1'b0;
    ck_run_o  = 1'b0;
    eng_en_o  = 1'b0;
    unique case (mode_i)
      MODE_HIZ:   ;
      MODE_OFF:   begin pad_oe_o = 1'b1; pad_lvl_o = 1'b1; end
      MODE_CYCLE: begin pad_oe_o = 1'b1; pad_lvl_o = 1'b0; end
      MODE_ON: begin
        ck_run_o  = 1'b1;
        pad_lvl_o = 1'b1;
        pad_oe_o  = !ready_i;   // lines idle high until engines take over
        eng_en_o  = ready_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/host_pwr_seq.sv
module host_pwr_seq
  import host_pwr_pkg::*;
#(
  parameter int unsigned STARTUP_TICKS = 74
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_pwr_i,
  input  logic       cfg_dirpol_i,
  input  logic       ck_tick_i,
  output logic [1:0] pwr_field_o,
  output logic       dir_pol_o,
  output logic       pad_oe_o,
  output logic       pad_lvl_o,
  output logic       ck_run_o,
  output logic       eng_en_o,
  output logic       ready_o
);
  pwr_mode_e mode;
  logic      ready;
  logic      clr;

  assign clr = cfg_we_i && (cfg_pwr_i != CODE_ON);

  pwr_mode_reg i_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .pwr_i    (cfg_pwr_i),
    .dirpol_i (cfg_dirpol_i),
    .field_o  (pwr_field_o),
    .dirpol_o (dir_pol_o),
    .mode_o   (mode)
  );

  startup_timer #(.STARTUP_TICKS(STARTUP_TICKS)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (mode == MODE_ON),
    .clr_i   (clr),
    .tick_i  (ck_tick_i),
    .ready_o (ready)
  );

  pad_decode i_dec (
    .mode_i    (mode),
    .ready_i   (ready),
    .pad_oe_o  (pad_oe_o),
    .pad_lvl_o (pad_lvl_o),
    .ck_run_o  (ck_run_o),
    .eng_en_o  (eng_en_o)
  );

  assign ready_o = ready;

  a_r2_off_drives_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_pwr_i == CODE_OFF) |=> pad_oe_o && pad_lvl_o && !ck_run_o && !eng_en_o);
  a_r3_rsvd_as_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_pwr_i == CODE_RSVD) |=> pad_oe_o && pad_lvl_o && !ck_run_o && !eng_en_o);
  a_r4_cycle_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_pwr_i == CODE_CYCLE) |=> pad_oe_o && !pad_lvl_o && !ck_run_o && !eng_en_o);
  a_r6_engine_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_en_o |-> ready_o);
  a_r8_rewrite_keeps_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && cfg_we_i && (cfg_pwr_i == CODE_ON) |=> ready_o);
  a_r5_on_clock_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_pwr_i == CODE_ON) |=> ck_run_o);
endmodule

// File: tb/test_host_pwr_seq.sv
module test_host_pwr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] pwr = 2'b00;
  logic       dirpol = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] field;
  logic       dpol, oe, lvl, ckr, eng, rdy;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  host_pwr_seq i_host_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_pwr_i(pwr),
    .cfg_dirpol_i(dirpol), .ck_tick_i(tick), .pwr_field_o(field),
    .dir_pol_o(dpol), .pad_oe_o(oe), .pad_lvl_o(lvl), .ck_run_o(ckr),
    .eng_en_o(eng), .ready_o(rdy)
  );

  // packed view: {oe, lvl, ck_run, eng, ready}
  function automatic logic [4:0] pads();
    return {oe, lvl, ckr, eng, rdy};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] code, logic pol);
    @(negedge clk);
    we = 1'b1; pwr = code; dirpol = pol;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 field", {6'd0, field}, 8'd0);
    check("R1 dirpol", {7'd0, dpol}, 8'd0);
    check("R1 pads released", {3'd0, pads()}, 8'b000_00000);
  endtask

  task automatic t_off();
    wr(2'b00, 1'b0);
    check("R2 off drive high", {3'd0, pads()}, 8'b000_11000);
    check("R10 field 00", {6'd0, field}, 8'd0);
  endtask

  task automatic t_reserved();
    wr(2'b01, 1'b0);
    check("R3 rsvd pads", {3'd0, pads()}, 8'b000_11000);
    check("R3 rsvd readback", {6'd0, field}, 8'd1);
  endtask

  task automatic t_cycle();
    wr(2'b10, 1'b0);
    check("R4 cycle drive low", {3'd0, pads()}, 8'b000_10000);
  endtask

  task automatic t_startup();
    wr(2'b11, 1'b0);
    check("R5 on startup", {3'd0, pads()}, 8'b000_11100);
    ticks(73);
    check("R6 not ready at 73", {3'd0, pads()}, 8'b000_11100);
    ticks(1);
    check("R6 ready at 74", {3'd0, pads()}, 8'b000_01111);
  endtask

  task automatic t_rewrite_on();
    wr(2'b11, 1'b0);
    check("R8 rewrite keeps ready", {3'd0, pads()}, 8'b000_01111);
    wr(2'b00, 1'b0);
    wr(2'b11, 1'b0);
    ticks(40);
    wr(2'b11, 1'b0);
    ticks(33);
    check("R8 count kept, 73", {7'd0, rdy}, 8'd0);
    ticks(1);
    check("R8 count kept, 74", {7'd0, rdy}, 8'd1);
  endtask

  task automatic t_restart();
    wr(2'b10, 1'b0);
    check("R7 clear on cycle", {7'd0, rdy}, 8'd0);
    wr(2'b11, 1'b0);
    ticks(73);
    check("R7 full restart 73", {7'd0, rdy}, 8'd0);
    ticks(1);
    check("R7 full restart 74", {7'd0, rdy}, 8'd1);
  endtask

  task automatic t_idle_ticks();
    wr(2'b00, 1'b0);
    ticks(100);
    check("R9 off ignores ticks", {3'd0, pads()}, 8'b000_11000);
    wr(2'b11, 1'b0);
    ticks(73);
    check("R9 no carry-over", {7'd0, rdy}, 8'd0);
    ticks(1);
    check("R9 ready after 74", {7'd0, rdy}, 8'd1);
  endtask

  task automatic t_dirpol();
    wr(2'b10, 1'b1);
    check("R10 dirpol set", {7'd0, dpol}, 8'd1);
    check("R10 field 10", {6'd0, field}, 8'd2);
    wr(2'b10, 1'b0);
    check("R10 dirpol clear", {7'd0, dpol}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_reserved();
    t_cycle();
    t_startup();
    t_rewrite_on();
    t_restart();
    t_idle_ticks();
    t_dirpol();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule